// File: doc/BRIEF.md
# SPI Command Register-File Slave

This block is the host-facing side of a CAN controller. An SPI master (mode 0, 8-bit bytes, MSB first, active-low chip select) sends an opcode byte and, depending on the opcode, an address and data bytes. The slave decodes the command and carries it out on a 128-byte register space.

Supported commands are byte write, sequential read, masked bit update, soft reset, shortcut loads into the three transmit buffers, shortcut reads of the two receive buffers, and a one-byte request-to-send. The control register holds a requested operating mode. The status register shows the accepted mode a cycle later. The three transmit-request flags and the accepted mode come out as plain ports. A protocol engine outside this block can write any register, such as received frame bytes, through a simple engine write port. The SPI pins are sampled by a faster system clock through synchronisers.

Top module: `spi_rf_slave`

## Requirements
- R1: Opcode 0x02, then an address byte, then data bytes. Each data byte is written to the current address, and the address then steps up by one. The address wraps from 0x7F to 0x00.
- R2: Opcode 0x03, then an address byte. From the third byte on, MISO shifts out the addressed register MSB first, and the address steps up by one per byte. A four-byte read at 0x2C returns registers 0x2C and 0x2D in order. MISO is 0 during every byte that carries no read data.
- R3: Opcode 0x05, then address, mask and data bytes. Each bit where the mask is 1 takes the data bit. Each bit where the mask is 0 keeps its old value.
- R4: After the synchronous reset or a 0xC0 opcode, every register is 0x00 except the following. The control register 0x0F reads 0x87, so (value AND 0x17) = 0x07. The status register 0x0E reads 0x80, which is mode 100b (configuration). All transmit requests are 0.
- R5: Bits [7:5] of the control register request a mode: 000 normal, 001 sleep, 010 loopback, 011 listen-only, 100 configuration. A legal code appears on op_mode and in status bits [7:5] one cycle later. Codes 101 to 111 leave the mode unchanged. Status bits [4:0] read 0, and writes to 0x0E are ignored.
- R6: Opcodes 0x40, 0x42 and 0x44 load transmit buffer 0, 1 or 2. The data bytes are written from address 0x31, 0x41 or 0x51 upward. Opcode 0x46 is treated as unknown.
- R7: Opcode 0x90 reads sequentially from 0x61. Opcode 0x94 reads sequentially from 0x71. Read data appears from the second byte on.
- R8: A single byte 0x80|m sets bit 3 of register 0x30, 0x40 or 0x50 for each set bit m[0], m[1] or m[2]. tx_req[i] always equals bit 3 of transmit control register i.
- R9: Raising chip select ends the command, and a partly received byte has no effect. An unknown opcode changes nothing, and MISO stays 0 until chip select rises.
- R10: eng_we writes eng_data to eng_addr on the next clock edge. Address 0x0E is excluded, and an SPI write or request-to-send in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, changes after falling SCK |
| eng_we | input | 1 | Engine write strobe |
| eng_addr | input | 7 | Engine write address |
| eng_data | input | 8 | Engine write data |
| tx_req | output | 3 | Transmit-request flag per transmit buffer |
| op_mode | output | 3 | Accepted operating mode |

## Verification
The assertions assume the following about the inputs. Each SCK half period lasts at least several system clocks, so a finished byte is decoded and the next read byte is loaded before the next falling SCK edge. An engine write never lands in the same cycle as an SPI write, where it would be dropped. The stimulus drives SCK with eight system clocks per half period and changes MOSI only while SCK is low. It pulses the engine port only while chip select is high. The bench model and the per-cycle comparison of tx_req and op_mode assume that the flags and mode settle within a few clocks of chip select rising.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_MODIFY  = 8'h05;
  localparam logic [7:0] OP_RESET   = 8'hC0;
  localparam logic [7:0] OP_RD_RX0  = 8'h90;
  localparam logic [7:0] OP_RD_RX1  = 8'h94;
  localparam logic [4:0] OP_LOAD_HI = 5'b01000;  // 0x40..0x47 family
  localparam logic [4:0] OP_RTS_HI  = 5'b10000;  // 0x80..0x87 family

  localparam int NUM_TXB     = 3;
  localparam int REG_STATUS  = 'h0E;
  localparam int REG_CTRL    = 'h0F;
  localparam int TXB_BASE    = 'h30;
  localparam int TXB_STRIDE  = 'h10;
  localparam int RXB0_FIRST  = 'h61;
  localparam int RXB1_FIRST  = 'h71;
  localparam int TXREQ_BIT   = 3;

  localparam logic [7:0] CTRL_RST    = 8'h87;
  localparam logic [2:0] MODE_CONFIG = 3'b100;

  typedef enum logic [2:0] {
    ST_OPCODE, ST_ADDR, ST_WDATA, ST_RDATA, ST_MASK, ST_MDATA, ST_SKIP
  } dec_state_t;

  typedef enum logic [1:0] { K_WRITE, K_READ, K_MODIFY } acc_kind_t;
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int              WIDTH  = 3,
  parameter int              STAGES = 2,
  parameter logic [WIDTH-1:0] INIT  = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rf_shifter.sv
module spi_rf_shifter (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       csn_s,
  input  logic       mosi_s,
  input  logic       load_en,
  input  logic [7:0] load_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso
);
  logic       sck_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;
  logic       rise, fall;

  assign rise = sck_s & ~sck_q;
  assign fall = ~sck_s & sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
      miso      <= 1'b0;
    end else begin
      sck_q     <= sck_s;
      byte_done <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
        tx_sr   <= '0;
        miso    <= 1'b0;
      end else begin
        if (rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_s};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sr, mosi_s};
          end
        end
        if (load_en) begin
          tx_sr <= load_byte;
        end else if (fall) begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  // R9: a deselected slave drives MISO low
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !miso);
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        wr_mask,
  input  logic [NUM_TXB-1:0] rts_set,
  input  logic              ext_we,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [7:0]        ext_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [NUM_TXB-1:0] tx_req,
  output logic [2:0]        op_mode
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);

  logic [7:0] mem [DEPTH];
  logic [2:0] stat_mode;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == REG_CTRL) ? CTRL_RST : 8'h00;
      stat_mode <= MODE_CONFIG;
    end else begin
      if (wr_en) begin
        if (wr_addr != A_STAT)
          mem[wr_addr] <= (mem[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
      end else if (|rts_set) begin
        for (int t = 0; t < NUM_TXB; t++)
          if (rts_set[t]) mem[ADDR_W'(TXB_BASE + t*TXB_STRIDE)][TXREQ_BIT] <= 1'b1;
      end else if (ext_we && ext_addr != A_STAT) begin
        mem[ext_addr] <= ext_data;
      end
      if (mem[A_CTRL][7:5] <= MODE_CONFIG) stat_mode <= mem[A_CTRL][7:5];
    end
  end

  assign rd_data = (rd_addr == A_STAT) ? {stat_mode, 5'b0} : mem[rd_addr];
  assign op_mode = stat_mode;

  generate
    for (genvar t = 0; t < NUM_TXB; t++) begin : g_txreq
      assign tx_req[t] = mem[ADDR_W'(TXB_BASE + t*TXB_STRIDE)][TXREQ_BIT];
    end
  endgenerate

  // R4: soft reset lands on the documented control/status defaults
  assert_reset_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (((mem[A_CTRL] & 8'h17) == 8'h07) && (stat_mode == MODE_CONFIG)));

  // R3: bits outside the mask survive any write
  assert_mask_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst && wr_addr != A_STAT) |=>
      ((mem[$past(wr_addr)] & ~$past(wr_mask)) == ($past(mem[wr_addr]) & ~$past(wr_mask))));

  // R5: legal mode codes are mirrored a cycle later
  assert_mode_mirror_R5: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && mem[A_CTRL][7:5] <= MODE_CONFIG) |=> (op_mode == $past(mem[A_CTRL][7:5])));

  // R5: status register cannot be written
  assert_status_ro_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst && wr_addr == A_STAT) |=> $stable(mem[A_STAT]));

  // R8: request-to-send raises the selected flags
  assert_rts_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (|rts_set && !soft_rst && !wr_en) |=> ((tx_req & $past(rts_set)) == $past(rts_set)));
endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
  import spi_rf_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_sck,
  input  logic               spi_cs_n,
  input  logic               spi_mosi,
  output logic               spi_miso,
  input  logic               eng_we,
  input  logic [ADDR_W-1:0]  eng_addr,
  input  logic [7:0]         eng_data,
  output logic [NUM_TXB-1:0] tx_req,
  output logic [2:0]         op_mode
);
  localparam logic [ADDR_W-1:0] A_RX0  = ADDR_W'(RXB0_FIRST);
  localparam logic [ADDR_W-1:0] A_RX1  = ADDR_W'(RXB1_FIRST);
  localparam logic [ADDR_W-1:0] A_TXLD = ADDR_W'(TXB_BASE + 1);
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

  logic csn_s, sck_s, mosi_s;
  logic byte_done, load_en;
  logic [7:0] rx_byte, rd_data;

  dec_state_t state, nxt_state;
  acc_kind_t  kind, nxt_kind;
  logic [ADDR_W-1:0] addr, nxt_addr, rd_addr;
  logic [7:0] mask, nxt_mask, wr_mask;
  logic wr_en, soft_rst_c;
  logic [NUM_TXB-1:0] rts_set;

  spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sck, spi_mosi}),
    .q({csn_s, sck_s, mosi_s})
  );

  spi_rf_shifter u_shift (
    .clk(clk), .rst(rst), .sck_s(sck_s), .csn_s(csn_s), .mosi_s(mosi_s),
    .load_en(load_en), .load_byte(rd_data),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_rf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst_c),
    .wr_en(wr_en), .wr_addr(addr), .wr_data(rx_byte), .wr_mask(wr_mask),
    .rts_set(rts_set),
    .ext_we(eng_we), .ext_addr(eng_addr), .ext_data(eng_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .tx_req(tx_req), .op_mode(op_mode)
  );

  always_comb begin
    nxt_state  = state;
    nxt_kind   = kind;
    nxt_addr   = addr;
    nxt_mask   = mask;
    wr_en      = 1'b0;
    wr_mask    = 8'hFF;
    rts_set    = '0;
    soft_rst_c = 1'b0;
    load_en    = 1'b0;
    rd_addr    = addr;
    if (csn_s) begin
      nxt_state = ST_OPCODE;
    end else if (byte_done) begin
      case (state)
        ST_OPCODE: begin
          nxt_state = ST_SKIP;
          if (rx_byte == OP_WRITE) begin
            nxt_kind = K_WRITE;  nxt_state = ST_ADDR;
          end else if (rx_byte == OP_READ) begin
            nxt_kind = K_READ;   nxt_state = ST_ADDR;
          end else if (rx_byte == OP_MODIFY) begin
            nxt_kind = K_MODIFY; nxt_state = ST_ADDR;
          end else if (rx_byte == OP_RESET) begin
            soft_rst_c = 1'b1;
          end else if (rx_byte == OP_RD_RX0 || rx_byte == OP_RD_RX1) begin
            rd_addr   = rx_byte[2] ? A_RX1 : A_RX0;
            load_en   = 1'b1;
            nxt_addr  = rd_addr + ONE;
            nxt_state = ST_RDATA;
          end else if (rx_byte[7:3] == OP_RTS_HI) begin
            rts_set = rx_byte[NUM_TXB-1:0];
          end else if (rx_byte[7:3] == OP_LOAD_HI && !rx_byte[0]
                       && int'(rx_byte[2:1]) < NUM_TXB) begin
            nxt_addr  = A_TXLD + ADDR_W'({rx_byte[2:1], 4'h0});
            nxt_state = ST_WDATA;
          end
        end
        ST_ADDR: begin
          rd_addr  = rx_byte[ADDR_W-1:0];
          nxt_addr = rx_byte[ADDR_W-1:0];
          case (kind)
            K_READ: begin
              load_en   = 1'b1;
              nxt_addr  = rx_byte[ADDR_W-1:0] + ONE;
              nxt_state = ST_RDATA;
            end
            K_MODIFY: nxt_state = ST_MASK;
            default:  nxt_state = ST_WDATA;
          endcase
        end
        ST_WDATA: begin
          wr_en    = 1'b1;
          nxt_addr = addr + ONE;
        end
        ST_RDATA: begin
          load_en  = 1'b1;
          nxt_addr = addr + ONE;
        end
        ST_MASK: begin
          nxt_mask  = rx_byte;
          nxt_state = ST_MDATA;
        end
        ST_MDATA: begin
          wr_en     = 1'b1;
          wr_mask   = mask;
          nxt_state = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPCODE;
      kind  <= K_WRITE;
      addr  <= '0;
      mask  <= '0;
    end else begin
      state <= nxt_state;
      kind  <= nxt_kind;
      addr  <= nxt_addr;
      mask  <= nxt_mask;
    end
  end

  // R1: each completed data byte of a write advances the address, wrapping
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !csn_s && state == ST_WDATA) |=> (addr == $past(addr) + ONE));

  // R9: deselect always returns the decoder to opcode reception
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (csn_s && state != ST_OPCODE) |=> (state == ST_OPCODE));
endmodule

// File: tb/sim_spi_rf_slave.sv
module sim_spi_rf_slave;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic eng_we = 1'b0;
  logic [6:0] eng_addr = '0;
  logic [7:0] eng_data = '0;
  logic [2:0] tx_req, op_mode;

  always #4 clk = ~clk;

  spi_rf_slave u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .eng_we(eng_we), .eng_addr(eng_addr), .eng_data(eng_data),
    .tx_req(tx_req), .op_mode(op_mode)
  );

  int n_cmp = 0, n_bad = 0;
  bit settled = 0, done = 0;
  logic [7:0] mdl [128];
  int mdl_mode;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];
  logic [7:0] expb [16];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic void mdl_mirror();
    if (int'(mdl[15][7:5]) <= 4) mdl_mode = int'(mdl[15][7:5]);
  endfunction

  function automatic void mdl_reset();
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    mdl[15] = 8'h87;
    mdl_mode = 4;
  endfunction

  function automatic logic [7:0] mdl_rd(input int a);
    return (a == 14) ? 8'(mdl_mode << 5) : mdl[a];
  endfunction

  function automatic void mdl_wr(input int a, input logic [7:0] v, input logic [7:0] m);
    if (a != 14) mdl[a] = (mdl[a] & ~m) | (v & m);
    mdl_mirror();
  endfunction

  // Behavioural command interpreter over whole bytes
  function automatic void mdl_run(input int n);
    int op, a;
    for (int k = 0; k < 16; k++) expb[k] = 8'h00;
    if (n == 0) return;
    op = int'(txb[0]);
    if (op == 'h02) begin
      a = int'(txb[1]) % 128;
      for (int k = 2; k < n; k++) begin mdl_wr(a, txb[k], 8'hFF); a = (a + 1) % 128; end
    end else if (op == 'h03) begin
      a = int'(txb[1]) % 128;
      for (int k = 2; k < n; k++) begin expb[k] = mdl_rd(a); a = (a + 1) % 128; end
    end else if (op == 'h05) begin
      if (n >= 4) mdl_wr(int'(txb[1]) % 128, txb[3], txb[2]);
    end else if (op == 'hC0) begin
      mdl_reset();
    end else if (op == 'h40 || op == 'h42 || op == 'h44) begin
      a = 'h31 + 16 * ((op >> 1) & 3);
      for (int k = 1; k < n; k++) begin mdl_wr(a, txb[k], 8'hFF); a = (a + 1) % 128; end
    end else if (op == 'h90 || op == 'h94) begin
      a = (op == 'h90) ? 'h61 : 'h71;
      for (int k = 1; k < n; k++) begin expb[k] = mdl_rd(a); a = (a + 1) % 128; end
    end else if (op >= 'h80 && op <= 'h87) begin
      for (int t = 0; t < 3; t++) if (op[t]) mdl[16*t + 'h30][3] = 1'b1;
    end
  endfunction

  // Drive one transaction: n whole bytes plus optional partial bits
  task automatic run(input string tag, input int n, input int extra,
                     input logic [7:0] b0 = 0, input logic [7:0] b1 = 0,
                     input logic [7:0] b2 = 0, input logic [7:0] b3 = 0,
                     input logic [7:0] b4 = 0, input logic [7:0] b5 = 0,
                     input logic [7:0] b6 = 0, input logic [7:0] b7 = 0);
    txb[0] = b0; txb[1] = b1; txb[2] = b2; txb[3] = b3;
    txb[4] = b4; txb[5] = b5; txb[6] = b6; txb[7] = b7;
    settled = 0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = txb[k][b];
        repeat (HP) @(negedge clk);
        sck = 1'b1;
        rxb[k][b] = miso;
        repeat (HP) @(negedge clk);
        sck = 1'b0;
      end
    end
    for (int b = 7; b > 7 - extra; b--) begin
      mosi = txb[n][b];
      repeat (HP) @(negedge clk);
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (12) @(negedge clk);
    mdl_run(n);
    for (int k = 0; k < n; k++) chk(tag, int'(rxb[k]), int'(expb[k]));
    settled = 1;
  endtask

  task automatic poke(input int a, input logic [7:0] v);
    @(negedge clk);
    eng_we = 1'b1; eng_addr = 7'(a); eng_data = v;
    @(negedge clk);
    eng_we = 1'b0;
    if (a != 14) mdl[a] = v;
    mdl_mirror();
    repeat (3) @(negedge clk);
  endtask

  // Per-cycle comparison of the observable flags against the model
  always @(negedge clk) begin
    if (settled && !rst) begin
      chk("R8 tx_req", int'(tx_req), int'({mdl['h50][3], mdl['h40][3], mdl['h30][3]}));
      chk("R5 op_mode", int'(op_mode), mdl_mode);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    mdl_reset();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    settled = 1;

    // R4: reset state of status and control
    run("R4", 4, 0, 8'h03, 8'h0E);
    chk("R4 ctrl mask", int'(rxb[3] & 8'h17), 'h07);

    // R10 + R2: engine writes, then the paired flag read
    poke('h2C, 8'hA5);
    poke('h2D, 8'h3C);
    run("R2 R10", 4, 0, 8'h03, 8'h2C);

    // R1 / R2: sequential write and read-back
    run("R1", 5, 0, 8'h02, 8'h20, 8'h11, 8'h22, 8'h33);
    run("R2", 6, 0, 8'h03, 8'h1F, 8'h00, 8'h00, 8'h00, 8'h00);

    // R1: address wrap 0x7F -> 0x00
    run("R1 wrap", 4, 0, 8'h02, 8'h7F, 8'h9A, 8'h5B);
    run("R1 wrap rd", 4, 0, 8'h03, 8'h7F);

    // R3: masked update
    run("R3", 4, 0, 8'h05, 8'h20, 8'h0F, 8'hF5);
    run("R3 rd", 3, 0, 8'h03, 8'h20);
    chk("R3 value", int'(rxb[2]), 'h15);

    // R5: mode requests, illegal codes, read-only status
    run("R5", 3, 0, 8'h02, 8'h0F, 8'h40);
    run("R5 rd", 4, 0, 8'h03, 8'h0E);
    run("R5 bad", 3, 0, 8'h02, 8'h0F, 8'hE7);
    run("R5 stat wr", 3, 0, 8'h02, 8'h0E, 8'hFF);
    run("R5 rd2", 4, 0, 8'h03, 8'h0E);
    chk("R5 status", int'(rxb[2]), 'h40);
    run("R5 bm", 4, 0, 8'h05, 8'h0F, 8'hE0, 8'h60);
    run("R5 rd3", 4, 0, 8'h03, 8'h0E);

    // R6: transmit buffer loads
    run("R6", 5, 0, 8'h42, 8'h01, 8'h02, 8'h03, 8'h04);
    run("R6 rd", 7, 0, 8'h03, 8'h40);
    run("R6 b0", 3, 0, 8'h40, 8'hC1, 8'hC2);
    run("R6 b2", 3, 0, 8'h44, 8'hE1, 8'hE2);
    run("R6 rd2", 5, 0, 8'h03, 8'h50);

    // R7: receive buffer reads
    poke('h61, 8'h71); poke('h62, 8'h72); poke('h63, 8'h73);
    poke('h71, 8'h81); poke('h72, 8'h82);
    run("R7 rx0", 4, 0, 8'h90);
    run("R7 rx1", 3, 0, 8'h94);

    // R8: request-to-send
    run("R8", 1, 0, 8'h85);
    run("R8 rd", 3, 0, 8'h03, 8'h30);
    run("R8 b1", 1, 0, 8'h82);

    // R9: unknown opcodes and aborted byte
    run("R9 unk", 3, 0, 8'h33, 8'h20, 8'hAA);
    run("R9 unk46", 3, 0, 8'h46, 8'h99, 8'h98);
    run("R9 rd", 3, 0, 8'h03, 8'h20);
    run("R9 abort", 2, 4, 8'h02, 8'h21, 8'hEE);
    run("R9 rd2", 3, 0, 8'h03, 8'h21);

    // R4: soft reset
    run("R4 soft", 1, 0, 8'hC0);
    run("R4 rd", 4, 0, 8'h03, 8'h0E);
    run("R4 rd2", 3, 0, 8'h03, 8'h20);

    repeat (10) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule